// File: doc/BRIEF.md
# PWM Pair Fault Brake Controller

This block sits between a two-channel PWM generator (an even and an odd channel) and the output pins. It watches five fault inputs: two external pins, an ADC result monitor event, a system-fail event and a software-raised event. When a fault is seen it drives each channel of the pair to the safe level programmed for that channel. The fault inputs are assumed to be already synchronised to the block clock.

There are two detection paths, and each has its own per-source enable mask. The edge path reacts to a rising transition of its enabled, OR-combined sources. It latches interrupt flags until software clears them. The level path follows the live fault condition. On both paths a channel returns to its normal PWM waveform only on a period-start strobe from the PWM counter. On the edge path that strobe must also come after the channel's own flag has been cleared. The counter, input filtering and interrupt routing sit outside this block.

Top module: `pwmPairBrake`

## Requirements
- R1: After reset, all edge flags, level flags, edge status bits and level status bits are 0, and each output equals its raw PWM input.
- R2: In a cycle where the OR of `faultIn & edgeEn` is 1 and was 0 in the previous cycle (0 is assumed before the first cycle after reset), both edge flags and both edge status bits read 1 from the next cycle. A source that is held high causes only one detection, and sources whose edge-enable bit is 0 are ignored.
- R3: An edge flag clears only on a clear pulse for its own channel (`edgeClr` bit 0 for even, bit 1 for odd). If a new edge detection falls in the same cycle as the clear pulse, the flag stays 1.
- R4: An edge status bit clears in the cycle after a `periodStart` pulse during which that channel's edge flag already reads 0 and no new edge is detected. Otherwise it stays 1.
- R5: In every cycle where the OR of `faultIn & levelEn` is 1, both level flags and both level status bits read 1 from the next cycle.
- R6: A level flag clears on its channel's `levelClr` pulse only while no level fault is present. A level status bit clears after a `periodStart` pulse with no level fault present, whatever its flag holds.
- R7: A channel is braked while its edge status or its level status is 1. While braked, action 3 drives the output 1 and action 2 drives it 0. Actions 0 and 1 pass the PWM input through. An unbraked channel always passes its PWM input through.
- R8: When edge and level braking overlap on one channel, the channel stays braked until both status bits have cleared.
- R9: The even and odd channels are released independently. Clearing one channel's edge flag never releases the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| faultIn | input | 5 | Synchronised fault sources |
| edgeEn | input | 5 | Per-source enable mask for the edge path |
| levelEn | input | 5 | Per-source enable mask for the level path |
| actEven | input | 2 | Brake action for the even channel (3 high, 2 low, else none) |
| actOdd | input | 2 | Brake action for the odd channel |
| periodStart | input | 1 | One-cycle strobe at the start of each PWM period |
| pwmEven | input | 1 | Raw even-channel PWM waveform |
| pwmOdd | input | 1 | Raw odd-channel PWM waveform |
| edgeClr | input | 2 | Write-one-to-clear pulses for the edge flags (bit 0 even, bit 1 odd) |
| levelClr | input | 2 | Write-one-to-clear pulses for the level flags (bit 0 even, bit 1 odd) |
| outEven | output | 1 | Gated even-channel output |
| outOdd | output | 1 | Gated odd-channel output |
| edgeFlag | output | 2 | Edge interrupt flags (bit 0 even, bit 1 odd) |
| levelFlag | output | 2 | Level interrupt flags |
| edgeSts | output | 2 | Edge brake status bits |
| levelSts | output | 2 | Level brake status bits |

## Verification
Random fault patterns that toggle rarely and are held for many cycles separate single edge detection from repeated triggering on a held input. They also show the edge path apart from the level path, which follows the live fault. Clear pulses and period strobes are issued independently per channel, which shows whether release waits for both the flag clear and the next period start, and whether the two channels stay independent. Directed cases cover a clear landing in the same cycle as a new edge, overlapping edge and level faults, and all four action codes on each channel.

// File: rtl/brakePkg.sv
package brakePkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic              edgeHit;
    logic              levelHit;
    logic              periodStart;
    logic [NUM_CH-1:0] edgeClr;
    logic [NUM_CH-1:0] levelClr;
  } brakeStrobes_t;
endpackage

// File: rtl/faultCtrl.sv
module faultCtrl
  import brakePkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] edgeEn,
  input  logic [NUM_SRC-1:0] levelEn,
  input  logic               periodStart,
  input  logic [NUM_CH-1:0]  edgeClr,
  input  logic [NUM_CH-1:0]  levelClr,
  output brakeStrobes_t      strobes
);
  logic edgeSrc;
  logic edgeSrcQ;
  logic levelSrc;

  // Combined, enabled fault views for each path
  assign edgeSrc  = |(faultIn & edgeEn);
  assign levelSrc = |(faultIn & levelEn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edgeSrcQ <= 1'b0;
    else        edgeSrcQ <= edgeSrc;
  end

  always_comb begin
    strobes.edgeHit     = edgeSrc & ~edgeSrcQ;
    strobes.levelHit    = levelSrc;
    strobes.periodStart = periodStart;
    strobes.edgeClr     = edgeClr;
    strobes.levelClr    = levelClr;
  end
endmodule

// File: rtl/brakeDatapath.sv
module brakeDatapath
  import brakePkg::*;
#(
  parameter int ACT_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  brakeStrobes_t           strobes,
  input  logic [NUM_CH*ACT_W-1:0] actSel,
  input  logic [NUM_CH-1:0]       pwmIn,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       edgeFlag,
  output logic [NUM_CH-1:0]       edgeSts,
  output logic [NUM_CH-1:0]       levelFlag,
  output logic [NUM_CH-1:0]       levelSts
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             braked;
    logic [ACT_W-1:0] act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edgeFlag[c]  <= 1'b0;
        edgeSts[c]   <= 1'b0;
        levelFlag[c] <= 1'b0;
        levelSts[c]  <= 1'b0;
      end else begin
        // Edge path: a new hit wins over a software clear
        if (strobes.edgeHit)         edgeFlag[c] <= 1'b1;
        else if (strobes.edgeClr[c]) edgeFlag[c] <= 1'b0;
        // Release only on a period start after the flag is gone
        if (strobes.edgeHit)                              edgeSts[c] <= 1'b1;
        else if (strobes.periodStart && !edgeFlag[c])     edgeSts[c] <= 1'b0;
        // Level path follows the live fault
        if (strobes.levelHit)         levelFlag[c] <= 1'b1;
        else if (strobes.levelClr[c]) levelFlag[c] <= 1'b0;
        if (strobes.levelHit)         levelSts[c] <= 1'b1;
        else if (strobes.periodStart) levelSts[c] <= 1'b0;
      end
    end

    assign act       = actSel[c*ACT_W +: ACT_W];
    assign braked    = edgeSts[c] | levelSts[c];
    // Action codes with the top bit set force the output to the low bit
    assign pwmOut[c] = (braked && act[ACT_W-1]) ? act[0] : pwmIn[c];
  end
endmodule

// File: rtl/pwmPairBrake.sv
module pwmPairBrake
  import brakePkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ACT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] faultIn,
  input  logic [NUM_SRC-1:0] edgeEn,
  input  logic [NUM_SRC-1:0] levelEn,
  input  logic [ACT_W-1:0]   actEven,
  input  logic [ACT_W-1:0]   actOdd,
  input  logic               periodStart,
  input  logic               pwmEven,
  input  logic               pwmOdd,
  input  logic [1:0]         edgeClr,
  input  logic [1:0]         levelClr,
  output logic               outEven,
  output logic               outOdd,
  output logic [1:0]         edgeFlag,
  output logic [1:0]         levelFlag,
  output logic [1:0]         edgeSts,
  output logic [1:0]         levelSts
);
  brakeStrobes_t     strobes;
  logic [NUM_CH-1:0] pwmOutVec;

  faultCtrl #(.NUM_SRC(NUM_SRC)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .faultIn(faultIn), .edgeEn(edgeEn),
    .levelEn(levelEn), .periodStart(periodStart), .edgeClr(edgeClr),
    .levelClr(levelClr), .strobes(strobes)
  );

  brakeDatapath #(.ACT_W(ACT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .actSel({actOdd, actEven}), .pwmIn({pwmOdd, pwmEven}),
    .pwmOut(pwmOutVec), .edgeFlag(edgeFlag), .edgeSts(edgeSts),
    .levelFlag(levelFlag), .levelSts(levelSts)
  );

  assign outEven = pwmOutVec[0];
  assign outOdd  = pwmOutVec[1];
endmodule

// File: rtl/pwmPairBrakeChecker.sv
module pwmPairBrakeChecker #(
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] faultIn,
  input logic [NUM_SRC-1:0] edgeEn,
  input logic [NUM_SRC-1:0] levelEn,
  input logic [1:0]         actEven,
  input logic               periodStart,
  input logic [1:0]         edgeClr,
  input logic               outEven,
  input logic [1:0]         edgeFlag,
  input logic [1:0]         levelFlag,
  input logic [1:0]         edgeSts,
  input logic [1:0]         levelSts
);
  logic prevEdge;
  logic edgeRise;
  logic levelNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevEdge <= 1'b0;
    else        prevEdge <= |(faultIn & edgeEn);
  end
  assign edgeRise = (|(faultIn & edgeEn)) && !prevEdge;
  assign levelNow = |(faultIn & levelEn);

  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    edgeRise |=> (edgeFlag == 2'b11) && (edgeSts == 2'b11));

  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeFlag[0] && !edgeClr[0]) |=> edgeFlag[0]);

  a_r4_edge_release: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeSts[0] && periodStart && !edgeFlag[0] && !edgeRise) |=> !edgeSts[0]);

  a_r5_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    levelNow |=> (levelFlag == 2'b11) && (levelSts == 2'b11));

  a_r6_level_release: assert property (@(posedge clk) disable iff (!rst_n)
    (levelSts[1] && periodStart && !levelNow) |=> !levelSts[1]);

  a_r7_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((edgeSts[0] || levelSts[0]) && actEven == 2'd3) |-> outEven);

  a_r7_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((edgeSts[0] || levelSts[0]) && actEven == 2'd2) |-> !outEven);
endmodule

bind pwmPairBrake pwmPairBrakeChecker #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .faultIn(faultIn), .edgeEn(edgeEn),
  .levelEn(levelEn), .actEven(actEven), .periodStart(periodStart),
  .edgeClr(edgeClr), .outEven(outEven), .edgeFlag(edgeFlag),
  .levelFlag(levelFlag), .edgeSts(edgeSts), .levelSts(levelSts)
);

// File: tb/pwmPairBrake_tb.sv
module pwmPairBrake_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] faultIn = '0, edgeEn = '0, levelEn = '0;
  logic [1:0] actEven = '0, actOdd = '0, edgeClr = '0, levelClr = '0;
  logic       periodStart = 1'b0, pwmEven = 1'b0, pwmOdd = 1'b0;
  logic       outEven, outOdd;
  logic [1:0] edgeFlag, levelFlag, edgeSts, levelSts;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state built from the requirements
  bit       mPrev;
  bit [1:0] mEF, mES, mLF, mLS;

  always #5 clk = ~clk;

  pwmPairBrake dut_i (
    .clk(clk), .rst_n(rst_n), .faultIn(faultIn), .edgeEn(edgeEn),
    .levelEn(levelEn), .actEven(actEven), .actOdd(actOdd),
    .periodStart(periodStart), .pwmEven(pwmEven), .pwmOdd(pwmOdd),
    .edgeClr(edgeClr), .levelClr(levelClr), .outEven(outEven),
    .outOdd(outOdd), .edgeFlag(edgeFlag), .levelFlag(levelFlag),
    .edgeSts(edgeSts), .levelSts(levelSts)
  );

  function automatic bit expOut(bit braked, bit [1:0] act, bit pwm);
    if (braked && act == 2'd3) return 1'b1;
    if (braked && act == 2'd2) return 1'b0;
    return pwm;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check("R2/R3 edgeFlag", edgeFlag, mEF);
    check("R4/R9 edgeSts", edgeSts, mES);
    check("R5/R6 levelFlag", levelFlag, mLF);
    check("R5/R6 levelSts", levelSts, mLS);
    check("R7/R8 outEven", {1'b0, outEven},
          {1'b0, expOut(mES[0] | mLS[0], actEven, pwmEven)});
    check("R7/R8 outOdd", {1'b0, outOdd},
          {1'b0, expOut(mES[1] | mLS[1], actOdd, pwmOdd)});
  endtask

  // One clock: predict from current inputs, clock, compare after the edge
  task automatic tick();
    bit eSrc, hit, lSrc;
    bit [1:0] nEF, nES, nLF, nLS;
    eSrc = |(faultIn & edgeEn);
    hit  = eSrc && !mPrev;
    lSrc = |(faultIn & levelEn);
    for (int c = 0; c < 2; c++) begin
      nEF[c] = hit ? 1'b1 : (edgeClr[c] ? 1'b0 : mEF[c]);
      nES[c] = hit ? 1'b1 : ((periodStart && !mEF[c]) ? 1'b0 : mES[c]);
      nLF[c] = lSrc ? 1'b1 : (levelClr[c] ? 1'b0 : mLF[c]);
      nLS[c] = lSrc ? 1'b1 : (periodStart ? 1'b0 : mLS[c]);
    end
    @(posedge clk);
    #1;
    mPrev = eSrc; mEF = nEF; mES = nES; mLF = nLF; mLS = nLS;
    compareAll();
  endtask

  task automatic quiet();
    periodStart = 1'b0; edgeClr = '0; levelClr = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mPrev = 0; mEF = 0; mES = 0; mLF = 0; mLS = 0;
    pwmEven = 1'b1; pwmOdd = 1'b0; actEven = 2'd2; actOdd = 2'd3;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, outputs pass the PWM through
    compareAll();
    rst_n = 1'b1;
    tick();

    // R2: disabled source ignored, then held enabled source detected once
    edgeEn = 5'b00010; faultIn = 5'b00001; tick(); tick();
    faultIn = 5'b00011; tick(); tick(); tick();
    // R3: clear in the same cycle as a new edge keeps the flag
    faultIn = 5'b00000; tick();
    faultIn = 5'b00010; edgeClr = 2'b01; tick(); quiet();
    // R9: clear only the even flag, then period start releases only even
    edgeClr = 2'b01; tick(); quiet(); tick();
    periodStart = 1'b1; tick(); quiet(); tick();
    edgeClr = 2'b10; tick(); quiet();
    periodStart = 1'b1; tick(); quiet();
    faultIn = 5'b00000; tick();

    // R5/R6: level follows, release regardless of flag
    levelEn = 5'b10000; faultIn = 5'b10000; tick(); tick();
    levelClr = 2'b11; tick(); quiet();
    faultIn = 5'b00000; tick();
    periodStart = 1'b1; tick(); quiet(); tick();
    levelClr = 2'b11; tick(); quiet();

    // R8: overlapping edge and level faults on both channels
    faultIn = 5'b10010; tick(); tick();
    edgeClr = 2'b11; tick(); quiet();
    periodStart = 1'b1; tick(); quiet();
    faultIn = 5'b00000; tick();
    periodStart = 1'b1; tick(); quiet(); tick();

    // R7: every action code on each channel, braked and unbraked
    for (int a = 0; a < 4; a++) begin
      actEven = a[1:0]; actOdd = 2'(3 - a);
      faultIn = 5'b10000; pwmEven = a[0]; pwmOdd = ~a[0]; tick(); tick();
      faultIn = 5'b00000; periodStart = 1'b1; tick(); quiet(); tick();
    end

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        edgeEn = 5'($urandom); levelEn = 5'($urandom);
      end
      if (i % 37 == 0) begin
        actEven = 2'($urandom); actOdd = 2'($urandom);
      end
      for (int b = 0; b < 5; b++)
        if ($urandom_range(15) == 0) faultIn[b] = ~faultIn[b];
      periodStart = ($urandom_range(5) == 0);
      edgeClr  = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      levelClr = {($urandom_range(7) == 0), ($urandom_range(7) == 0)};
      pwmEven = 1'($urandom); pwmOdd = 1'($urandom);
      tick();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule